// File: doc/BRIEF.md
# Analog Test Bus Interface Switch Controller

This block is the digital side of the interface between two external analog test pins and two internal analog test buses. A boundary-scan data register, shifted in serially and applied on the update step, holds one 4-bit field per pin. Each field, combined with the current test mode from the instruction decoder, selects which switches close. The switches can link a pin to its bus, tap the bus for sensing, or put a fixed high or low level on the pin. A bus that is not in use is tied to a quiet clamp reference.

Moving a bus between clamped and live always passes through a cycle in which the clamp and the bus switches are all open. This break-before-make step is sequenced per bus. The same register's capture step records the digitised result of each pin's threshold comparator, after a synchronizer, so the test controller can read it back through the scan chain. The analog switches, the comparators and the clamp source lie outside the block. It produces only the enables.

Top module: `tbic_ctrl`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) leaves all drive, link and tap enables at 0, both clamp enables at 1, and the control register at zero.
- R2: With sel_i and shift_dr_i high, the 8-bit scan register shifts one place toward bit 0 on each clock. tdi_i enters bit 7, and tdo_o always shows bit 0, so data leaves LSB first.
- R3: The control register loads the scan register contents on a clock edge with update_dr_i and sel_i both high. In every other cycle it holds its value, including an update pulse with sel_i low.
- R4: A clock edge with sel_i and capture_dr_i high loads the scan register with the synchronized comparator results in bits 1:0 (pin 0 in bit 0), and with zeros in bits 7:2. Capture takes priority over shift.
- R5: Pin p uses control bits [4p+3:4p]. Bit 0 of the field requests the link switch, bit 1 the tap switch, and bits 3:2 the level code: 01 drive low, 10 drive high, 00 and 11 no drive. In drive mode the drive enables follow the field in the same cycle the control register changes.
- R6: mode_i encodes 00 off, 01 drive, 10 probe and 11 off. Drive mode honours every field. Probe mode honours link and tap and forces both drive enables to 0. Off mode closes no link, tap or drive switch.
- R7: For each pin, drv_hi_o and drv_lo_o are never 1 together.
- R8: For each bus, clamp_o is 1 exactly when the bus is settled idle, and it is never 1 in the same cycle as link_o or tap_o of that pin.
- R9: When a bus becomes requested while clamped, its clamp opens one clock after the control change, and the requested link and tap switches close one clock after that. This leaves one cycle with everything open.
- R10: When a live bus loses its last request, its link and tap enables drop in the same cycle as the control change. The bus stays open for one clock, and the clamp closes on the second clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (test logic reset) |
| mode_i | input | 2 | Test mode from instruction decode: 00 off, 01 drive, 10 probe, 11 off |
| sel_i | input | 1 | This data register is selected by the current instruction |
| capture_dr_i | input | 1 | Capture step of the data register |
| shift_dr_i | input | 1 | Shift step of the data register |
| update_dr_i | input | 1 | Update step of the data register |
| tdi_i | input | 1 | Serial scan input |
| cmp_i | input | 2 | Raw comparator results, one per pin |
| tdo_o | output | 1 | Serial scan output (bit 0 of the scan register) |
| drv_hi_o | output | 2 | Enable for the fixed high level onto each pin |
| drv_lo_o | output | 2 | Enable for the fixed low level onto each pin |
| link_o | output | 2 | Enable for each pin-to-bus connect switch |
| tap_o | output | 2 | Enable for each bus sense switch |
| clamp_o | output | 2 | Enable for each bus clamp switch |

## Verification
A corrupted control field shows on the drive enables in the first cycle after the update edge. A corrupted bus sequencer state shows within two clocks as a clamp that overlaps a link, a missing gap cycle, or a clamp that never returns. The bench sweeps all 256 register patterns in drive mode and checks every enable after the settling window. It also counts edge by edge through the connect and release sequences, so a state that skips or doubles the gap is caught on the exact cycle. Capture and serial shift faults appear on tdo_o during the following read-out.

// File: rtl/tbic_pkg.sv
package tbic_pkg;

    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned FIELD_W  = 4;
    localparam int unsigned CTRL_W   = NUM_PINS * FIELD_W;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_DRIVE = 2'b01,
        MODE_PROBE = 2'b10,
        MODE_RSVD  = 2'b11
    } tb_mode_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } lvl_e;

    // per-pin control field, packed so that bit 0 is the link request
    typedef struct packed {
        lvl_e level;
        logic tap;
        logic link;
    } pin_field_t;

    typedef struct packed {
        logic drv_hi;
        logic drv_lo;
        logic tap;
        logic link;
    } pin_req_t;

    typedef enum logic [1:0] {
        BUS_CLAMP = 2'b00,
        BUS_GAP   = 2'b01,
        BUS_LIVE  = 2'b10
    } bus_state_e;

    function automatic pin_req_t decode_field(input pin_field_t f, input tb_mode_e m);
        pin_req_t r;
        r = '0;
        if (m == MODE_DRIVE || m == MODE_PROBE) begin
            r.link = f.link;
            r.tap  = f.tap;
        end
        if (m == MODE_DRIVE) begin
            r.drv_hi = (f.level == LVL_HIGH);
            r.drv_lo = (f.level == LVL_LOW);
        end
        return r;
    endfunction

endpackage

// File: rtl/tbic_sync.sv
module tbic_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/tbic_scan_reg.sv
module tbic_scan_reg
    import tbic_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                capture,
    input  logic                shift,
    input  logic                update,
    input  logic                tdi,
    input  logic [NUM_PINS-1:0] cmp_raw,
    output logic                tdo,
    output logic [CTRL_W-1:0]   ctrl_q
);

    localparam int unsigned PAD_W = CTRL_W - NUM_PINS;

    logic [NUM_PINS-1:0] cmp_sync;
    logic [CTRL_W-1:0]   shift_q;

    tbic_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (cmp_raw),
        .q   (cmp_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (sel && capture) begin
            shift_q <= {{PAD_W{1'b0}}, cmp_sync};
        end else if (sel && shift) begin
            shift_q <= {tdi, shift_q[CTRL_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (sel && update) begin
            ctrl_q <= shift_q;
        end
    end

    assign tdo = shift_q[0];

    // control register only moves on a selected update
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(sel && update) |=> $stable(ctrl_q));

    // after a capture, the padding bits read back as zero
    assert_capture_pad_R4: assert property (@(posedge clk) disable iff (rst)
        (sel && capture) |=> (shift_q[CTRL_W-1:NUM_PINS] == '0));

endmodule

// File: rtl/tbic_decode.sv
module tbic_decode
    import tbic_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CTRL_W-1:0]        ctrl,
    input  tb_mode_e                 mode,
    output pin_req_t [NUM_PINS-1:0]  req
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign req[p] = decode_field(pin_field_t'(ctrl[p*FIELD_W +: FIELD_W]), mode);

        // probe and off modes never request a fixed level
        assert_probe_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
            (mode != MODE_DRIVE) |-> (!req[p].drv_hi && !req[p].drv_lo));
    end

endmodule

// File: rtl/tbic_bus_seq.sv
module tbic_bus_seq
    import tbic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic link_req,
    input  logic tap_req,
    output logic link_en,
    output logic tap_en,
    output logic clamp_en
);

    bus_state_e state_q, state_d;
    logic       want;

    assign want = link_req || tap_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_CLAMP: if (want)  state_d = BUS_GAP;
            BUS_GAP:   state_d = want ? BUS_LIVE : BUS_CLAMP;
            BUS_LIVE:  if (!want) state_d = BUS_GAP;
            default:   state_d = BUS_CLAMP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_CLAMP;
        else     state_q <= state_d;
    end

    assign clamp_en = (state_q == BUS_CLAMP);
    assign link_en  = (state_q == BUS_LIVE) && link_req;
    assign tap_en   = (state_q == BUS_LIVE) && tap_req;

    assert_no_clamp_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(clamp_en && (link_en || tap_en)));

    // connecting only after a cycle with the clamp open
    assert_bbm_connect_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(link_en) || $rose(tap_en)) |-> $past(!clamp_en));

    // clamp released into an all-open cycle
    assert_bbm_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_en) |-> (!link_en && !tap_en));

    // clamp only returns after a cycle with the bus switches open
    assert_bbm_release_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_en) |-> $past(!link_en && !tap_en));

endmodule

// File: rtl/tbic_ctrl.sv
module tbic_ctrl
    import tbic_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic                sel_i,
    input  logic                capture_dr_i,
    input  logic                shift_dr_i,
    input  logic                update_dr_i,
    input  logic                tdi_i,
    input  logic [NUM_PINS-1:0] cmp_i,
    output logic                tdo_o,
    output logic [NUM_PINS-1:0] drv_hi_o,
    output logic [NUM_PINS-1:0] drv_lo_o,
    output logic [NUM_PINS-1:0] link_o,
    output logic [NUM_PINS-1:0] tap_o,
    output logic [NUM_PINS-1:0] clamp_o
);

    logic [CTRL_W-1:0]       ctrl_q;
    pin_req_t [NUM_PINS-1:0] req;
    tb_mode_e                mode;

    assign mode = tb_mode_e'(mode_i);

    tbic_scan_reg #(.SYNC_STAGES(SYNC_STAGES)) scan_i (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_i),
        .capture (capture_dr_i),
        .shift   (shift_dr_i),
        .update  (update_dr_i),
        .tdi     (tdi_i),
        .cmp_raw (cmp_i),
        .tdo     (tdo_o),
        .ctrl_q  (ctrl_q)
    );

    tbic_decode dec_i (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl_q),
        .mode (mode),
        .req  (req)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bus
        assign drv_hi_o[p] = req[p].drv_hi;
        assign drv_lo_o[p] = req[p].drv_lo;

        tbic_bus_seq seq_i (
            .clk      (clk),
            .rst      (rst),
            .link_req (req[p].link),
            .tap_req  (req[p].tap),
            .link_en  (link_o[p]),
            .tap_en   (tap_o[p]),
            .clamp_en (clamp_o[p])
        );
    end

    assert_drive_excl_R7: assert property (@(posedge clk) disable iff (rst)
        (drv_hi_o & drv_lo_o) == '0);

    assert_off_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 || mode_i == 2'b11) |-> (drv_hi_o == '0 && drv_lo_o == '0 && link_o == '0 && tap_o == '0));

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (clamp_o == '1 && link_o == '0 && tap_o == '0 && drv_hi_o == '0 && drv_lo_o == '0));

endmodule

// File: tb/tbic_ctrl_tb.sv
module tbic_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic       sel_i = 1'b0;
    logic       capture_dr_i = 1'b0;
    logic       shift_dr_i = 1'b0;
    logic       update_dr_i = 1'b0;
    logic       tdi_i = 1'b0;
    logic [1:0] cmp_i = 2'b00;
    logic       tdo_o;
    logic [1:0] drv_hi_o, drv_lo_o, link_o, tap_o, clamp_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tbic_ctrl dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .sel_i(sel_i),
        .capture_dr_i(capture_dr_i), .shift_dr_i(shift_dr_i), .update_dr_i(update_dr_i),
        .tdi_i(tdi_i), .cmp_i(cmp_i), .tdo_o(tdo_o),
        .drv_hi_o(drv_hi_o), .drv_lo_o(drv_lo_o), .link_o(link_o),
        .tap_o(tap_o), .clamp_o(clamp_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_in(input logic [7:0] d);
        sel_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            shift_dr_i = 1'b1;
            tdi_i = d[i];
            tick();
        end
        shift_dr_i = 1'b0;
        tdi_i = 1'b0;
    endtask

    task automatic do_update(input logic sel_val);
        sel_i = sel_val;
        update_dr_i = 1'b1;
        tick();
        update_dr_i = 1'b0;
        sel_i = 1'b1;
    endtask

    task automatic scan_write(input logic [7:0] d);
        shift_in(d);
        do_update(1'b1);
    endtask

    task automatic shift_out(output logic [7:0] d);
        sel_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            d[i] = tdo_o;
            shift_dr_i = 1'b1;
            tick();
        end
        shift_dr_i = 1'b0;
    endtask

    // expected enables for one pattern and mode, from R5/R6
    task automatic check_pattern(input string req, input logic [7:0] d, input logic [1:0] m, input bit settled);
        logic [1:0] ehi, elo, elink, etap;
        for (int p = 0; p < 2; p++) begin
            logic [3:0] f;
            f = d[p*4 +: 4];
            ehi[p]   = (m == 2'b01) && (f[3:2] == 2'b10);
            elo[p]   = (m == 2'b01) && (f[3:2] == 2'b01);
            elink[p] = (m == 2'b01 || m == 2'b10) && f[0];
            etap[p]  = (m == 2'b01 || m == 2'b10) && f[1];
        end
        chk(req, "drv_hi", 32'(drv_hi_o), 32'(ehi));
        chk(req, "drv_lo", 32'(drv_lo_o), 32'(elo));
        chk("R7", "hi/lo overlap", 32'(drv_hi_o & drv_lo_o), 32'h0);
        if (settled) begin
            chk(req, "link", 32'(link_o), 32'(elink));
            chk(req, "tap", 32'(tap_o), 32'(etap));
            chk("R8", "clamp", 32'(clamp_o), 32'(~(elink | etap) & 2'b11));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk("R1", "clamp", 32'(clamp_o), 32'h3);
        chk("R1", "link|tap|drv", 32'(link_o | tap_o | drv_hi_o | drv_lo_o), 32'h0);
        chk("R1", "tdo", 32'(tdo_o), 32'h0);
    endtask

    task automatic t_shift_path();
        logic [7:0] got;
        shift_in(8'hC5);
        shift_out(got);
        chk("R2", "shift-through LSB first", 32'(got), 32'hC5);
        shift_in(8'h3A);
        shift_out(got);
        chk("R2", "shift-through second pattern", 32'(got), 32'h3A);
    endtask

    task automatic t_capture();
        logic [7:0] got;
        cmp_i = 2'b10;
        repeat (4) tick();
        shift_in(8'hFF);
        capture_dr_i = 1'b1;
        shift_dr_i = 1'b1;
        tick();
        capture_dr_i = 1'b0;
        shift_dr_i = 1'b0;
        shift_out(got);
        chk("R4", "capture cmp=10 over shift", 32'(got), 32'h02);
        cmp_i = 2'b01;
        repeat (4) tick();
        capture_dr_i = 1'b1;
        tick();
        capture_dr_i = 1'b0;
        shift_out(got);
        chk("R4", "capture cmp=01", 32'(got), 32'h01);
        cmp_i = 2'b00;
    endtask

    task automatic t_ignored_update();
        mode_i = 2'b01;
        scan_write(8'h08);
        chk("R5", "pin0 high", 32'(drv_hi_o), 32'h1);
        shift_in(8'h40);
        do_update(1'b0);
        tick();
        chk("R3", "deselected update keeps drv_hi", 32'(drv_hi_o), 32'h1);
        chk("R3", "deselected update keeps drv_lo", 32'(drv_lo_o), 32'h0);
        scan_write(8'h00);
        tick(); tick();
    endtask

    task automatic t_connect_release();
        mode_i = 2'b01;
        scan_write(8'h01);
        chk("R9", "clamp still closed at update", 32'(clamp_o), 32'h3);
        chk("R9", "link still open at update", 32'(link_o), 32'h0);
        tick();
        chk("R9", "gap clamp", 32'(clamp_o), 32'h2);
        chk("R9", "gap link", 32'(link_o), 32'h0);
        tick();
        chk("R9", "live link", 32'(link_o), 32'h1);
        chk("R9", "live clamp", 32'(clamp_o), 32'h2);
        scan_write(8'h00);
        chk("R10", "link drops at once", 32'(link_o), 32'h0);
        chk("R10", "clamp open at update", 32'(clamp_o), 32'h2);
        tick();
        chk("R10", "gap clamp", 32'(clamp_o), 32'h2);
        tick();
        chk("R10", "clamp back", 32'(clamp_o), 32'h3);
    endtask

    task automatic t_sweep();
        mode_i = 2'b01;
        for (int v = 0; v < 256; v++) begin
            scan_write(8'(v));
            check_pattern("R5", 8'(v), 2'b01, 1'b0);
            tick(); tick();
            check_pattern("R5", 8'(v), 2'b01, 1'b1);
        end
        scan_write(8'h00);
        tick(); tick();
    endtask

    task automatic t_modes();
        mode_i = 2'b01;
        scan_write(8'hAB);
        tick(); tick();
        check_pattern("R6", 8'hAB, 2'b01, 1'b1);
        mode_i = 2'b10;
        #1;
        chk("R6", "probe drops drive at once", 32'(drv_hi_o | drv_lo_o), 32'h0);
        tick(); tick();
        check_pattern("R6", 8'hAB, 2'b10, 1'b1);
        mode_i = 2'b00;
        tick(); tick();
        check_pattern("R6", 8'hAB, 2'b00, 1'b1);
        mode_i = 2'b11;
        tick(); tick();
        check_pattern("R6", 8'hAB, 2'b11, 1'b1);
        mode_i = 2'b00;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_shift_path();
        t_capture();
        t_ignored_update();
        t_connect_release();
        t_sweep();
        t_modes();
        t_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule